// File: doc/BRIEF.md
# Serial Link Activity and Line-Driver Enable

This block sits beside a UART core and turns its status lines into pins. Two indicator pins report transmit and receive traffic. Each rests high when its direction is quiet and blinks slowly, at a rate set by a clock-count parameter, while traffic flows. The default rate is about 7.5 Hz, a half-period of roughly 66.7 ms. A third function drives the direction-enable of a half-duplex differential line transceiver. The enable is asserted while the UART sends data or a break. It stays asserted for a programmable number of bit times after the final stop bit, so the line driver does not drop before the last bit has settled.

The receive indicator and the transceiver enable share one pin. A static mode input picks which of the two appears on it. A second static input sets the enable polarity. Every interface here is a plain level or pulse control pin: no data flows through the block, so it has no valid/ready handshake and applies no back-pressure. `bit_tick_i` is a one-cycle pulse, one per bit period, aligned with the UART's bit boundaries.

Top module: `xind_top`

## Requirements
- R1: While reset is asserted, `tx_act_o` is 1 and the enable is deasserted. On `pin2_o` the deasserted level is 0 when `de_act_low_i`=0 and 1 when `de_act_low_i`=1. In receive-indicator mode `pin2_o` is 1.
- R2: An indicator whose direction has been idle longer than two half-periods reads 1 and stays at 1.
- R3: When activity starts from idle, the indicator reads 0 on the next clock. While activity continues it inverts every `BLINK_HALF` clocks.
- R4: When activity stops, the indicator keeps its current half-period. At the end of the first half-period that saw no activity, it returns to 1 and goes idle.
- R5: The enable is asserted on the clock after `tx_busy_i` or `brk_busy_i` is high. It remains asserted while either input stays high.
- R6: A break on its own (`brk_busy_i`=1 with `tx_busy_i`=0) asserts the enable.
- R7: Once both busy inputs are low, the enable stays asserted until the `HOLD_BITS`-th `bit_tick_i` pulse that arrives with both inputs low. It releases on that clock. A tick in a cycle where either busy input is high is not counted.
- R8: If transmission resumes during the hold, the enable stays asserted with no deasserted cycle, and the hold count starts over.
- R9: The asserted enable level is 1 when `de_act_low_i`=0 and 0 when `de_act_low_i`=1.
- R10: With `rs485_sel_i`=0, `pin2_o` carries the receive indicator. With `rs485_sel_i`=1 it carries the enable level, and receive activity has no effect on it.
- R11: `tx_act_o` depends only on transmit activity. The mode and polarity inputs and receive activity do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_busy_i | input | 1 | UART is sending a character |
| rx_busy_i | input | 1 | UART is receiving a character |
| brk_busy_i | input | 1 | UART is sending a line break |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| rs485_sel_i | input | 1 | 0: pin2 is the receive indicator; 1: pin2 is the transceiver enable |
| de_act_low_i | input | 1 | 1: enable is active low |
| tx_act_o | output | 1 | Transmit activity indicator, idles high |
| pin2_o | output | 1 | Receive indicator or transceiver enable |

## Verification
The bench goes after the moment the enable should release. A design that counts the tick falling in the last busy cycle would cut the final stop bit short, and one that ignores ticks would never release. A transmission that resumes inside the hold is sampled on every cycle, which exposes a design that drops the enable for a single clock. On the indicators, the bench checks that the blink pattern finishes its current half-period after activity stops. A design that snaps the pin high at once, or never returns it high, fails those checks. The polarity and mode table shows that receive traffic leaks onto neither the enable pin nor the transmit indicator.

// File: rtl/xind_pkg.sv
package xind_pkg;
  typedef enum logic {BL_IDLE = 1'b0, BL_RUN = 1'b1} blink_st_e;
  typedef enum logic {P2_RX_ACT = 1'b0, P2_DRV_EN = 1'b1} pin2_mode_e;
  localparam int NCH = 2;  // channel 0: transmit, channel 1: receive
endpackage

// File: rtl/xind_blink.sv
module xind_blink
  import xind_pkg::*;
#(
  parameter int HALF = 8_333_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic act_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  blink_st_e     st;
  logic [CW-1:0] cnt;
  logic          seen;
  logic          pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= BL_IDLE;
      cnt  <= '0;
      seen <= 1'b0;
      pin  <= 1'b1;
    end else begin
      unique case (st)
        BL_IDLE: begin
          if (busy_i) begin
            st   <= BL_RUN;
            pin  <= 1'b0;
            cnt  <= '0;
            seen <= 1'b0;
          end
        end
        BL_RUN: begin
          if (cnt == LAST) begin
            cnt  <= '0;
            seen <= 1'b0;
            if (seen || busy_i) begin
              pin <= ~pin;
            end else begin
              pin <= 1'b1;
              st  <= BL_IDLE;
            end
          end else begin
            cnt  <= cnt + 1'b1;
            seen <= seen | busy_i;
          end
        end
        default: st <= BL_IDLE;
      endcase
    end
  end

  assign act_o = pin;
endmodule

// File: rtl/xind_de_hold.sv
module xind_de_hold #(
  parameter int HOLD_BITS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_busy_i,
  input  logic brk_busy_i,
  input  logic bit_tick_i,
  output logic de_on_o
);
  localparam int TW = $clog2(HOLD_BITS + 1);
  localparam logic [TW-1:0] TLAST = TW'(HOLD_BITS - 1);

  logic          drive_req;
  logic          on_q;
  logic [TW-1:0] tcnt;

  assign drive_req = tx_busy_i | brk_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      tcnt <= '0;
    end else if (drive_req) begin
      on_q <= 1'b1;
      tcnt <= '0;
    end else if (on_q && bit_tick_i) begin
      if (tcnt == TLAST) begin
        on_q <= 1'b0;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign de_on_o = on_q;
endmodule

// File: rtl/xind_top.sv
module xind_top
  import xind_pkg::*;
#(
  parameter int BLINK_HALF = 8_333_333,
  parameter int HOLD_BITS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  input  logic brk_busy_i,
  input  logic bit_tick_i,
  input  logic rs485_sel_i,
  input  logic de_act_low_i,
  output logic tx_act_o,
  output logic pin2_o
);
  logic [NCH-1:0] busy_v;
  logic [NCH-1:0] act_v;
  logic           de_on;
  logic           de_level;
  pin2_mode_e     mode;

  assign busy_v = {rx_busy_i, tx_busy_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    xind_blink #(.HALF(BLINK_HALF)) u_blink (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_v[g]),
      .act_o  (act_v[g])
    );
  end

  xind_de_hold #(.HOLD_BITS(HOLD_BITS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_busy_i  (tx_busy_i),
    .brk_busy_i (brk_busy_i),
    .bit_tick_i (bit_tick_i),
    .de_on_o    (de_on)
  );

  assign de_level = de_on ^ de_act_low_i;
  assign mode     = pin2_mode_e'(rs485_sel_i);

  always_comb begin
    unique case (mode)
      P2_DRV_EN: pin2_o = de_level;
      default:   pin2_o = act_v[1];
    endcase
  end

  assign tx_act_o = act_v[0];
endmodule

// File: rtl/xind_chk.sv
module xind_chk #(
  parameter int BLINK_HALF = 8_333_333,
  parameter int HOLD_BITS  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic tx_busy_i,
  input logic rx_busy_i,
  input logic brk_busy_i,
  input logic bit_tick_i,
  input logic rs485_sel_i,
  input logic de_act_low_i,
  input logic tx_act_o,
  input logic pin2_o
);
  localparam logic [31:0] QLIM = 32'(2 * BLINK_HALF);
  localparam logic [31:0] TLIM = 32'(HOLD_BITS);

  logic [31:0] tx_quiet;
  logic [31:0] rx_quiet;
  logic [31:0] idle_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_quiet   <= '0;
      rx_quiet   <= '0;
      idle_ticks <= '0;
    end else begin
      if (tx_busy_i) tx_quiet <= '0;
      else if (tx_quiet < QLIM) tx_quiet <= tx_quiet + 1;
      if (rx_busy_i) rx_quiet <= '0;
      else if (rx_quiet < QLIM) rx_quiet <= rx_quiet + 1;
      if (tx_busy_i || brk_busy_i) idle_ticks <= '0;
      else if (bit_tick_i && idle_ticks < TLIM) idle_ticks <= idle_ticks + 1;
    end
  end

  a_r5_enable_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_i || brk_busy_i) |=> (!rs485_sel_i || (pin2_o != de_act_low_i)));

  a_r7_enable_released: assert property (@(posedge clk) disable iff (!rst_n)
    (rs485_sel_i && idle_ticks >= TLIM) |-> (pin2_o == de_act_low_i));

  a_r4_tx_returns_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_quiet >= QLIM) |-> tx_act_o);

  a_r10_rx_returns_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs485_sel_i && rx_quiet >= QLIM) |-> pin2_o);
endmodule

bind xind_top xind_chk #(.BLINK_HALF(BLINK_HALF), .HOLD_BITS(HOLD_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_busy_i    (tx_busy_i),
  .rx_busy_i    (rx_busy_i),
  .brk_busy_i   (brk_busy_i),
  .bit_tick_i   (bit_tick_i),
  .rs485_sel_i  (rs485_sel_i),
  .de_act_low_i (de_act_low_i),
  .tx_act_o     (tx_act_o),
  .pin2_o       (pin2_o)
);

// File: tb/xind_top_test.sv
`timescale 1ns/1ps
module xind_top_test;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_busy = 1'b0, rx_busy = 1'b0, brk_busy = 1'b0, tick = 1'b0;
  logic sel = 1'b0, pol = 1'b0;
  logic tx_act, pin2;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  xind_top #(.BLINK_HALF(HALF), .HOLD_BITS(1)) uut (
    .clk(clk), .rst_n(rst_n), .tx_busy_i(tx_busy), .rx_busy_i(rx_busy),
    .brk_busy_i(brk_busy), .bit_tick_i(tick), .rs485_sel_i(sel),
    .de_act_low_i(pol), .tx_act_o(tx_act), .pin2_o(pin2)
  );

  // fields: [6]sel [5]pol [4]tx [3]brk [2]rx [1]expected pin2 [0]expected tx_act
  localparam logic [6:0] VEC [9] = '{
    7'b0000011, 7'b0010010, 7'b0000101, 7'b1010010, 7'b1001011,
    7'b1110000, 7'b1100011, 7'b1000101, 7'b1101101
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic tick_pulse();
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state under each mode/polarity
    cyc(2);
    check("R1 tx_act in reset", tx_act, 1'b1);
    check("R1 pin2 rx mode in reset", pin2, 1'b1);
    sel = 1'b1; #1;
    check("R1 pin2 enable off active-high", pin2, 1'b0);
    pol = 1'b1; #1;
    check("R1 pin2 enable off active-low", pin2, 1'b1);
    sel = 1'b0; pol = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cyc(2);

    // table: R6 R9 R10 R11
    for (int i = 0; i < 9; i++) begin
      sel = VEC[i][6]; pol = VEC[i][5];
      tx_busy = VEC[i][4]; brk_busy = VEC[i][3]; rx_busy = VEC[i][2];
      cyc(3);
      check($sformatf("R9/R10/R6 row %0d pin2", i), pin2, VEC[i][1]);
      check($sformatf("R11 row %0d tx_act", i), tx_act, VEC[i][0]);
      tx_busy = 1'b0; brk_busy = 1'b0; rx_busy = 1'b0;
      cyc(1);
      tick_pulse();
      cyc(25);
    end

    // R3 R4 R2: blink timing, transmit channel
    sel = 1'b0; pol = 1'b0;
    tx_busy = 1'b1;
    cyc(1);
    check("R3 start low", tx_act, 1'b0);
    cyc(9);
    check("R3 low through first half", tx_act, 1'b0);
    cyc(1);
    check("R3 inverted after half", tx_act, 1'b1);
    cyc(9);
    check("R3 high through second half", tx_act, 1'b1);
    cyc(1);
    check("R3 low again", tx_act, 1'b0);
    tx_busy = 1'b0;
    cyc(9);
    check("R4 half-period completes", tx_act, 1'b0);
    cyc(1);
    check("R4 returns high", tx_act, 1'b1);
    cyc(30);
    check("R2 stays high when idle", tx_act, 1'b1);

    // R5 R7: enable and one-bit hold
    sel = 1'b1; pol = 1'b0;
    tx_busy = 1'b1;
    cyc(1);
    check("R5 enable asserted", pin2, 1'b1);
    tick_pulse();
    cyc(2);
    check("R7 tick while busy not counted", pin2, 1'b1);
    tx_busy = 1'b0;
    cyc(5);
    check("R7 held with no tick", pin2, 1'b1);
    tick_pulse();
    check("R7 released on tick", pin2, 1'b0);

    // R7: tick in the last busy cycle does not count
    tx_busy = 1'b1;
    cyc(2);
    tick = 1'b1;
    cyc(1);
    tx_busy = 1'b0; tick = 1'b0;
    cyc(3);
    check("R7 last-busy tick ignored", pin2, 1'b1);
    tick_pulse();
    check("R7 released after idle tick", pin2, 1'b0);

    // R8: restart during hold, sampled every cycle
    tx_busy = 1'b1;
    cyc(2);
    tx_busy = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      check($sformatf("R8 hold cycle %0d", k), pin2, 1'b1);
    end
    tx_busy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      check($sformatf("R8 resumed cycle %0d", k), pin2, 1'b1);
    end
    tx_busy = 1'b0;
    cyc(2);
    tick_pulse();
    check("R8 released after restart", pin2, 1'b0);

    // R6: break only, then its hold
    brk_busy = 1'b1;
    cyc(1);
    check("R6 break asserts enable", pin2, 1'b1);
    brk_busy = 1'b0;
    cyc(2);
    check("R6 break hold", pin2, 1'b1);
    tick_pulse();
    check("R6 break released", pin2, 1'b0);

    cyc(30);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule